// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block drives the transmit side of a network controller from a ring of descriptors held in system memory. The ring has a power-of-two number of entries, and each entry is two 32-bit words. The block reaches memory through a word-wide DMA master port with a request/ready handshake, and it has only one access outstanding at a time. While nothing is ready to send, it re-reads the descriptor at its current position once per poll period. When it finds a descriptor that it owns and that opens a packet, it loads the buffer address and the byte count. It then presents the buffer contents one 32-bit word at a time on a transmit data output.

A frame check word is taken from an external CRC engine. The block clears the engine at packet start, feeds it every data word, and sends the engine's result as the final word of the packet. This step can be switched off. A packet may span several chained descriptors. When a buffer has been consumed, the block hands that descriptor back to software by clearing its ownership bit in memory. At the end of a packet it pulses a done flag. If a packet's next buffer is not yet owned, the block writes an error flag into the descriptor, drops its transmitter-on output and halts until it is started again.

Descriptor layout. Word 0 holds the ownership bit at bit 31, the packet-start bit at bit 25, the packet-end bit at bit 24 and the 24-bit buffer byte address in bits 23:0. Word 1 holds the buffer-error flag at bit 30 and the negated byte count in bits 11:0.

Top module: `tx_ring_walker`

## Requirements
- R1: Descriptor n occupies the word addresses {8'hFF, ringBaseHi, 1'b0} + 2n (word 0) and that address plus one (word 1). The position advances modulo 2^ringLenLog2, so after the last entry the walk returns to entry 0.
- R2: While the descriptor at the current position has bit 31 clear, the block sends nothing. It re-reads that descriptor every POLL_CYCLES cycles and transmits as soon as ownership appears.
- R3: An owned descriptor without the start bit (bit 25), found while no packet is in progress, is skipped. Its memory words are left unchanged and the next position is polled.
- R4: The byte count is the two's complement of word 1 bits 11:0, and a result of zero means 4096 bytes. The number of data words sent is the byte count divided by four, rounded up.
- R5: Every DMA address has its top byte (bits 29:22) at all ones. Buffer data words are read from word address {8'hFF, bufAddr[23:2]}, advancing by one per word.
- R6: With crcOff low, crcClear pulses at packet start and crcAppend accompanies each data word. The packet-end buffer's count grows by 4, and its last word is crcResult. With crcOff high, no CRC word is sent.
- R7: A started buffer without the end bit (bit 24) is followed by the next owned descriptor's buffer in the same packet, without a new start bit, and with one done pulse for the whole packet.
- R8: If a buffer lacks the end bit and the next descriptor is not owned, the block writes word 1 back with bit 30 set, drops txOn, sends no data and stops.
- R9: After a buffer is consumed, word 0 is written back with bit 31 clear and the other bits unchanged. On a packet-end buffer, txDone pulses for one cycle.
- R10: dmaReq, dmaWrite, dmaAddr and dmaWdata hold steady from the moment a request is raised until dmaReady completes it.
- R11: start acts only while the block is stopped. It sets the position to 0 and raises txOn. A start pulse while txOn is high changes nothing.
- R12: After reset, dmaReq, txValid, txDone, crcClear and txOn are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, effective while stopped |
| ringBaseHi | input | 21 | Ring base byte address bits 23:3 |
| ringLenLog2 | input | LEN_W | Log2 of the ring entry count |
| crcOff | input | 1 | Suppress the CRC word |
| dmaReq | output | 1 | DMA access request |
| dmaWrite | output | 1 | Request is a write |
| dmaAddr | output | 30 | DMA word address |
| dmaWdata | output | 32 | DMA write data |
| dmaReady | input | 1 | Access completes this cycle |
| dmaRdata | input | 32 | Read data, valid with dmaReady |
| txValid | output | 1 | Transmit word valid |
| txData | output | 32 | Transmit word |
| crcClear | output | 1 | Reset the external CRC engine |
| crcAppend | output | 1 | Feed txData to the CRC engine |
| crcResult | input | 32 | CRC engine result |
| txDone | output | 1 | End-of-packet pulse |
| txOn | output | 1 | Transmitter running |

## Verification
A wrong ring position shows at the DMA address port on the very next descriptor read. It also shows one packet later in memory: the wrong descriptor is released, or an owned one is left unsent. A wrong byte count shows as a data word too many or too few before the ownership write-back. A lost end-of-packet or lookahead decision shows as a missing done pulse, a CRC word in the wrong place, or txOn falling when it should not, all within a few cycles of the buffer's last word.

// File: rtl/txr_pkg.sv
package txr_pkg;
  localparam int OwnBit    = 31;
  localparam int BufErrBit = 30;
  localparam int StartBit  = 25;
  localparam int EndBit    = 24;

  typedef enum logic [1:0] {AddrPos, AddrCur0, AddrCur1, AddrBuf} addrSel_e;

  typedef struct packed {
    logic     latchW0;
    logic     latchW1;
    logic     markCur;
    logic     advPos;
    logic     clearPos;
    logic     loadBuf;
    logic     stepBuf;
    logic     wrSel;     // 0: release word 0, 1: error word 1
    addrSel_e addrSel;
  } ctrlStrb_t;
endpackage

// File: rtl/txr_datapath.sv
module txr_datapath
  import txr_pkg::*;
#(
  parameter int MAX_LOG2 = 7,
  parameter int LEN_W    = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrb_t        strb,
  input  logic [20:0]      ringBaseHi,
  input  logic [LEN_W-1:0] ringLenLog2,
  input  logic             crcOff,
  input  logic [31:0]      dmaRdata,
  input  logic [31:0]      crcResult,
  output logic [29:0]      dmaAddr,
  output logic [31:0]      dmaWdata,
  output logic [31:0]      txData,
  output logic             curEnp,
  output logic             lastBeat,
  output logic             crcBeat
);
  localparam int CNT_W = 13;
  localparam int PAD_W = 29 - MAX_LOG2;

  logic [MAX_LOG2-1:0] pos, curPos, lenMask, posNext;
  logic [31:0]         w0, w1;
  logic [23:0]         bufAddr;
  logic [CNT_W-1:0]    count, step, loadCount;
  logic [11:0]         lenField;
  logic [29:0]         baseWord, posWord, curWord;
  logic                addCrc;

  always_comb begin
    for (int i = 0; i < MAX_LOG2; i++) lenMask[i] = (LEN_W'(i) < ringLenLog2);
  end

  assign posNext  = (pos + 1'b1) & lenMask;
  assign baseWord = {8'hFF, ringBaseHi, 1'b0};
  assign posWord  = baseWord + {{PAD_W{1'b0}}, pos, 1'b0};
  assign curWord  = baseWord + {{PAD_W{1'b0}}, curPos, 1'b0};

  assign curEnp   = w0[EndBit];
  assign addCrc   = !crcOff && w0[EndBit];
  assign lastBeat = (count <= CNT_W'(4));
  assign crcBeat  = addCrc && lastBeat;
  assign step     = (count >= CNT_W'(4)) ? CNT_W'(4) : count;

  assign lenField  = ~w1[11:0] + 12'd1;
  assign loadCount = ((lenField == 12'd0) ? CNT_W'(4096) : {1'b0, lenField})
                   + (addCrc ? CNT_W'(4) : CNT_W'(0));

  always_comb begin
    unique case (strb.addrSel)
      AddrPos:  dmaAddr = posWord;
      AddrCur0: dmaAddr = curWord;
      AddrCur1: dmaAddr = curWord + 30'd1;
      default:  dmaAddr = {8'hFF, bufAddr[23:2]};
    endcase
  end

  assign dmaWdata = strb.wrSel ? (w1 | (32'd1 << BufErrBit)) : (w0 & ~(32'd1 << OwnBit));
  assign txData   = crcBeat ? crcResult : dmaRdata;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pos     <= '0;
      curPos  <= '0;
      w0      <= '0;
      w1      <= '0;
      bufAddr <= '0;
      count   <= '0;
    end else begin
      if (strb.clearPos)    pos <= '0;
      else if (strb.advPos) pos <= posNext;
      if (strb.markCur) curPos <= pos;
      if (strb.latchW0) w0 <= dmaRdata;
      if (strb.latchW1) w1 <= dmaRdata;
      if (strb.loadBuf) begin
        bufAddr <= w0[23:0];
        count   <= loadCount;
      end else if (strb.stepBuf) begin
        bufAddr <= bufAddr + 24'(step);
        count   <= count - step;
      end
    end
  end
endmodule

// File: rtl/txr_ctrl.sv
module txr_ctrl
  import txr_pkg::*;
#(
  parameter int POLL_CYCLES = 200000
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      crcOff,
  input  logic      dmaReady,
  input  logic      rdOwn,
  input  logic      rdStart,
  input  logic      curEnp,
  input  logic      lastBeat,
  input  logic      crcBeat,
  output ctrlStrb_t strb,
  output logic      dmaReq,
  output logic      dmaWrite,
  output logic      txValid,
  output logic      txDone,
  output logic      txOn,
  output logic      crcClear,
  output logic      crcAppend
);
  localparam int CNT_W = $clog2(POLL_CYCLES + 1);

  typedef enum logic [3:0] {
    S_OFF, S_WAIT, S_POLL, S_W1, S_AHEAD, S_ERRW, S_PREP, S_BEAT, S_OWNW, S_CHAIN
  } state_e;

  state_e           state, stateNext;
  logic [CNT_W-1:0] waitCnt;
  logic             txOnNext;

  always_comb begin
    stateNext    = state;
    txOnNext     = txOn;
    strb         = '0;
    strb.addrSel = AddrPos;
    dmaReq       = 1'b0;
    dmaWrite     = 1'b0;
    txValid      = 1'b0;
    txDone       = 1'b0;
    crcClear     = 1'b0;
    crcAppend    = 1'b0;
    unique case (state)
      S_OFF: if (start) begin
        strb.clearPos = 1'b1;
        txOnNext      = 1'b1;
        stateNext     = S_POLL;
      end
      S_WAIT: if (waitCnt == '0) stateNext = S_POLL;
      S_POLL: begin
        dmaReq = 1'b1;
        if (dmaReady) begin
          strb.latchW0 = 1'b1;
          strb.markCur = 1'b1;
          if (!rdOwn) stateNext = S_WAIT;
          else if (!rdStart) begin
            strb.advPos = 1'b1;
            stateNext   = S_WAIT;
          end else begin
            crcClear  = 1'b1;
            stateNext = S_W1;
          end
        end
      end
      S_W1: begin
        dmaReq       = 1'b1;
        strb.addrSel = AddrCur1;
        if (dmaReady) begin
          strb.latchW1 = 1'b1;
          strb.advPos  = 1'b1;
          stateNext    = curEnp ? S_PREP : S_AHEAD;
        end
      end
      S_AHEAD: begin
        dmaReq = 1'b1;
        if (dmaReady) stateNext = rdOwn ? S_PREP : S_ERRW;
      end
      S_ERRW: begin
        dmaReq       = 1'b1;
        dmaWrite     = 1'b1;
        strb.wrSel   = 1'b1;
        strb.addrSel = AddrCur1;
        if (dmaReady) begin
          txOnNext  = 1'b0;
          stateNext = S_OFF;
        end
      end
      S_PREP: begin
        strb.loadBuf = 1'b1;
        stateNext    = S_BEAT;
      end
      S_BEAT: begin
        strb.addrSel = AddrBuf;
        if (crcBeat) begin
          txValid      = 1'b1;
          strb.stepBuf = 1'b1;
          stateNext    = S_OWNW;
        end else begin
          dmaReq = 1'b1;
          if (dmaReady) begin
            txValid      = 1'b1;
            crcAppend    = !crcOff;
            strb.stepBuf = 1'b1;
            if (lastBeat) stateNext = S_OWNW;
          end
        end
      end
      S_OWNW: begin
        dmaReq       = 1'b1;
        dmaWrite     = 1'b1;
        strb.addrSel = AddrCur0;
        if (dmaReady) begin
          txDone    = curEnp;
          stateNext = curEnp ? S_WAIT : S_CHAIN;
        end
      end
      S_CHAIN: begin
        dmaReq = 1'b1;
        if (dmaReady) begin
          strb.latchW0 = 1'b1;
          strb.markCur = 1'b1;
          stateNext    = rdOwn ? S_W1 : S_WAIT;
        end
      end
      default: stateNext = S_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_OFF;
      txOn    <= 1'b0;
      waitCnt <= '0;
    end else begin
      state <= stateNext;
      txOn  <= txOnNext;
      if (state == S_WAIT) waitCnt <= waitCnt - 1'b1;
      else                 waitCnt <= CNT_W'(POLL_CYCLES - 1);
    end
  end
endmodule

// File: rtl/tx_ring_walker.sv
module tx_ring_walker
  import txr_pkg::*;
#(
  parameter int POLL_CYCLES = 200000,
  parameter int MAX_LOG2    = 7,
  localparam int LEN_W      = $clog2(MAX_LOG2 + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [20:0]      ringBaseHi,
  input  logic [LEN_W-1:0] ringLenLog2,
  input  logic             crcOff,
  output logic             dmaReq,
  output logic             dmaWrite,
  output logic [29:0]      dmaAddr,
  output logic [31:0]      dmaWdata,
  input  logic             dmaReady,
  input  logic [31:0]      dmaRdata,
  output logic             txValid,
  output logic [31:0]      txData,
  output logic             crcClear,
  output logic             crcAppend,
  input  logic [31:0]      crcResult,
  output logic             txDone,
  output logic             txOn
);
  ctrlStrb_t strb;
  logic      curEnp, lastBeat, crcBeat;

  txr_ctrl #(.POLL_CYCLES(POLL_CYCLES)) i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .crcOff(crcOff), .dmaReady(dmaReady),
    .rdOwn(dmaRdata[OwnBit]), .rdStart(dmaRdata[StartBit]),
    .curEnp(curEnp), .lastBeat(lastBeat), .crcBeat(crcBeat), .strb(strb),
    .dmaReq(dmaReq), .dmaWrite(dmaWrite), .txValid(txValid), .txDone(txDone),
    .txOn(txOn), .crcClear(crcClear), .crcAppend(crcAppend)
  );

  txr_datapath #(.MAX_LOG2(MAX_LOG2), .LEN_W(LEN_W)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .ringBaseHi(ringBaseHi),
    .ringLenLog2(ringLenLog2), .crcOff(crcOff), .dmaRdata(dmaRdata),
    .crcResult(crcResult), .dmaAddr(dmaAddr), .dmaWdata(dmaWdata),
    .txData(txData), .curEnp(curEnp), .lastBeat(lastBeat), .crcBeat(crcBeat)
  );
endmodule

// File: rtl/txr_checker.sv
module txr_checker (
  input logic        clk,
  input logic        rstN,
  input logic        dmaReq,
  input logic        dmaWrite,
  input logic        dmaReady,
  input logic [29:0] dmaAddr,
  input logic [31:0] dmaWdata,
  input logic        txValid,
  input logic        txDone,
  input logic        txOn,
  input logic        crcClear,
  input logic        crcAppend
);
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    dmaReq && !dmaReady |=> dmaReq && $stable(dmaWrite) && $stable(dmaAddr) && $stable(dmaWdata));

  p_addr_top_r5: assert property (@(posedge clk) disable iff (!rstN)
    dmaReq |-> dmaAddr[29:22] == 8'hFF);

  p_done_release_r9: assert property (@(posedge clk) disable iff (!rstN)
    txDone |-> dmaReq && dmaWrite && dmaReady && !dmaWdata[31]);

  p_stop_after_err_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txOn) |-> $past(dmaReq && dmaWrite && dmaReady && dmaWdata[30]));

  p_tx_when_on_r11: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> txOn);

  p_append_valid_r6: assert property (@(posedge clk) disable iff (!rstN)
    crcAppend |-> txValid);

  p_clear_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    crcClear |-> !txValid && !crcAppend);
endmodule

bind tx_ring_walker txr_checker i_txr_checker (
  .clk(clk), .rstN(rstN), .dmaReq(dmaReq), .dmaWrite(dmaWrite), .dmaReady(dmaReady),
  .dmaAddr(dmaAddr), .dmaWdata(dmaWdata), .txValid(txValid), .txDone(txDone),
  .txOn(txOn), .crcClear(crcClear), .crcAppend(crcAppend)
);

// File: tb/test_tx_ring_walker.sv
module test_tx_ring_walker;
  localparam int POLL = 20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [20:0] ringBaseHi = 21'h000020;   // byte 0x000100 -> word 0x040
  logic [2:0]  ringLenLog2 = 3'd3;
  logic        crcOff = 1'b0;
  logic        dmaReq, dmaWrite, dmaReady, txValid, crcClear, crcAppend, txDone, txOn;
  logic [29:0] dmaAddr;
  logic [31:0] dmaWdata, dmaRdata, txData, crcResult;

  always #4 clk = ~clk;

  tx_ring_walker #(.POLL_CYCLES(POLL)) i_tx_ring_walker (
    .clk(clk), .rstN(rstN), .start(start), .ringBaseHi(ringBaseHi),
    .ringLenLog2(ringLenLog2), .crcOff(crcOff), .dmaReq(dmaReq), .dmaWrite(dmaWrite),
    .dmaAddr(dmaAddr), .dmaWdata(dmaWdata), .dmaReady(dmaReady), .dmaRdata(dmaRdata),
    .txValid(txValid), .txData(txData), .crcClear(crcClear), .crcAppend(crcAppend),
    .crcResult(crcResult), .txDone(txDone), .txOn(txOn)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  int memLat = 0;
  int latCnt = 0;
  int doneCnt = 0;
  int badHigh = 0;
  int badHold = 0;
  logic [31:0] mem [0:4095];
  logic [31:0] got[$];
  logic [31:0] expQ[$];
  logic [31:0] crcAcc;
  logic        holdValid = 1'b0;
  logic [29:0] holdAddr;

  // memory slave with programmable latency
  always @(posedge clk) begin
    dmaReady <= 1'b0;
    if (rstN && dmaReq && !dmaReady) begin
      if (latCnt >= memLat) begin
        dmaReady <= 1'b1;
        latCnt   <= 0;
        if (dmaWrite) mem[dmaAddr[11:0]] <= dmaWdata;
        else          dmaRdata <= mem[dmaAddr[11:0]];
      end else latCnt <= latCnt + 1;
    end
  end

  // external CRC engine model: rotate-and-xor
  always @(posedge clk) begin
    if (crcClear)       crcAcc <= 32'hFFFF_FFFF;
    else if (crcAppend) crcAcc <= {crcAcc[30:0], crcAcc[31]} ^ txData;
  end
  assign crcResult = crcAcc;

  always @(negedge clk) begin
    if (rstN) begin
      if (txValid) got.push_back(txData);
      if (txDone) doneCnt++;
      if (dmaReq && dmaAddr[29:22] != 8'hFF) badHigh++;
      if (holdValid && (!dmaReq || dmaAddr != holdAddr)) badHold++;
      holdValid = dmaReq && !dmaReady;
      holdAddr  = dmaAddr;
    end
  end

  function automatic logic [31:0] pat(input int i);
    return 32'h5A00_0000 ^ (i * 32'h0001_0003);
  endfunction

  function automatic logic [31:0] mkW0(input bit own, input bit stp, input bit enp, input logic [23:0] a);
    return {own, 5'd0, stp, enp, a};
  endfunction

  function automatic logic [31:0] mkW1(input int bytes);
    logic [11:0] neg = 12'(-bytes);
    return {20'h00000, neg};
  endfunction

  function automatic logic [31:0] crcOver(input int from, input int n);
    logic [31:0] a = 32'hFFFF_FFFF;
    for (int k = 0; k < n; k++) a = {a[30:0], a[31]} ^ expQ[from + k];
    return a;
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", rq, act, exp);
    end
  endtask

  task automatic setDesc(input int n, input logic [31:0] w0, input logic [31:0] w1);
    mem[12'h040 + 2 * n]     = w0;
    mem[12'h040 + 2 * n + 1] = w1;
  endtask

  task automatic resetDut(input logic [2:0] lg, input bit noCrc, input int lat);
    @(negedge clk);
    rstN = 1'b0;
    ringLenLog2 = lg;
    crcOff = noCrc;
    memLat = lat;
    for (int i = 0; i < 4096; i++) mem[i] = pat(i);
    for (int i = 0; i < 16; i++) setDesc(i, 32'd0, 32'd0);
    got.delete();
    expQ.delete();
    doneCnt = 0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic pulseStart();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone(input int n, input int maxCycles);
    for (int c = 0; c < maxCycles && doneCnt < n; c++) @(negedge clk);
  endtask

  task automatic cmpStream(input string rq);
    chk(rq, got.size(), expQ.size());
    for (int k = 0; k < expQ.size() && k < got.size(); k++) chk(rq, got[k], expQ[k]);
  endtask

  task automatic testReset();
    resetDut(3'd3, 1'b0, 0);
    chk("R12 dmaReq", dmaReq, 1'b0);
    chk("R12 txOn", txOn, 1'b0);
    chk("R12 txValid", txValid, 1'b0);
    chk("R12 txDone", txDone, 1'b0);
    chk("R12 crcClear", crcClear, 1'b0);
  endtask

  // R4 R6 R9: single buffer of 8 bytes with CRC
  task automatic testSingleCrc();
    resetDut(3'd3, 1'b0, 1);
    setDesc(0, mkW0(1, 1, 1, 24'h000400), mkW1(8));
    pulseStart();
    chk("R11 txOn after start", txOn, 1'b1);
    waitDone(1, 400);
    expQ.push_back(pat(12'h100));
    expQ.push_back(pat(12'h101));
    expQ.push_back(crcOver(0, 2));
    cmpStream("R6 data+crc");
    chk("R9 done count", doneCnt, 1);
    chk("R9 released word0", mem[12'h040], mkW0(0, 1, 1, 24'h000400));
  endtask

  // R3: owned non-start descriptor skipped, CRC off, odd byte count
  task automatic testSkip();
    resetDut(3'd3, 1'b1, 0);
    setDesc(0, mkW0(1, 0, 1, 24'h000600), mkW1(4));
    setDesc(1, mkW0(1, 1, 1, 24'h000800), mkW1(6));
    pulseStart();
    waitDone(1, 400);
    expQ.push_back(pat(12'h200));
    expQ.push_back(pat(12'h201));
    cmpStream("R4 six bytes no crc");
    chk("R3 skipped left owned", mem[12'h040], mkW0(1, 0, 1, 24'h000600));
    chk("R3 next released", mem[12'h042], mkW0(0, 1, 1, 24'h000800));
  endtask

  // R4: zero count field means 4096 bytes
  task automatic testFull();
    resetDut(3'd3, 1'b1, 0);
    setDesc(0, mkW0(1, 1, 1, 24'h002000), 32'd0);
    pulseStart();
    waitDone(1, 6000);
    for (int k = 0; k < 1024; k++) expQ.push_back(pat(12'h800 + k));
    chk("R4 4096 bytes word count", got.size(), 1024);
    cmpStream("R4 4096 bytes data");
  endtask

  // R7: chained buffers, one packet, CRC over both
  task automatic testChain();
    resetDut(3'd3, 1'b0, 2);
    setDesc(0, mkW0(1, 1, 0, 24'h000400), mkW1(12));
    setDesc(1, mkW0(1, 0, 1, 24'h000800), mkW1(5));
    pulseStart();
    waitDone(1, 800);
    for (int k = 0; k < 3; k++) expQ.push_back(pat(12'h100 + k));
    expQ.push_back(pat(12'h200));
    expQ.push_back(pat(12'h201));
    expQ.push_back(crcOver(0, 5));
    cmpStream("R7 chained stream");
    chk("R7 single done", doneCnt, 1);
    chk("R9 first released", mem[12'h040][31], 1'b0);
    chk("R9 second released", mem[12'h042][31], 1'b0);
  endtask

  // R8: next buffer not owned
  task automatic testBufErr();
    resetDut(3'd3, 1'b0, 1);
    setDesc(0, mkW0(1, 1, 0, 24'h000400), mkW1(8));
    pulseStart();
    repeat (60) @(negedge clk);
    chk("R8 txOn dropped", txOn, 1'b0);
    chk("R8 error flag written", mem[12'h041], mkW1(8) | 32'h4000_0000);
    chk("R8 no data", got.size(), 0);
    chk("R8 no done", doneCnt, 0);
    chk("R8 descriptor kept owned", mem[12'h040][31], 1'b1);
  endtask

  // R1 R2 R11: polling, ignored start, ring wrap at length 2
  task automatic testPollWrap();
    resetDut(3'd1, 1'b1, 0);
    setDesc(0, mkW0(0, 1, 1, 24'h000400), mkW1(4));
    setDesc(2, mkW0(1, 1, 1, 24'h000C00), mkW1(4));
    pulseStart();
    repeat (3 * POLL) @(negedge clk);
    chk("R2 nothing while unowned", got.size(), 0);
    mem[12'h040][31] = 1'b1;
    waitDone(1, POLL + 40);
    chk("R2 sent after ownership", doneCnt, 1);
    pulseStart();
    setDesc(1, mkW0(1, 1, 1, 24'h000800), mkW1(4));
    waitDone(2, 3 * POLL + 60);
    chk("R11 start ignored while on", doneCnt, 2);
    setDesc(0, mkW0(1, 1, 1, 24'h001000), mkW1(4));
    waitDone(3, 3 * POLL + 60);
    expQ.push_back(pat(12'h100));
    expQ.push_back(pat(12'h200));
    expQ.push_back(pat(12'h400));
    cmpStream("R1 wrap to entry 0");
    chk("R1 entry 2 untouched", mem[12'h044][31], 1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    testReset();
    testSingleCrc();
    testSkip();
    testFull();
    testChain();
    testBufErr();
    testPollWrap();
    chk("R5 address top byte", badHigh, 0);
    chk("R10 request held", badHold, 0);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule